// File: doc/BRIEF.md
# Pulse-Width Demodulating Capture Front End

This block measures the high and low phases of one alternating digital input using two capture channels. A free-running counter runs on the system clock. Each channel copies that counter into its own capture register when its count input rises. In demodulation mode, channel 0 takes the synchronized measurement input as it is and channel 1 takes its inverse. Channel 0 therefore captures at every rising edge and channel 1 at every falling edge of the measured signal. Software subtracts one capture from the other to get the phase length in clock cycles.

With demodulation off, each channel counts on its own external timer input. A timer pin that has been handed to general-purpose I/O is forced to read high so that it never produces an edge. Each capture raises a one-cycle interrupt pulse and sets a sticky flag, which a write-one-to-clear strobe resets. A second capture while the flag is still set marks an overrun. The channel 1 request shares an interrupt line with an external request, and a select input can move that external request onto a separate line.

Top module: `pwd_capture`

## Requirements
- R1: After reset, both capture registers read 0, and all flags, overrun bits and interrupt outputs are low.
- R2: With `demod_en_i` high, a rising edge on `pwd_i` captures the counter into `cap0_o` and pulses `irq0_o` high for exactly one cycle. A falling edge on `pwd_i` captures into `cap1_o` and pulses the channel 1 request. The pulse is visible on the third rising clock edge after the input changes.
- R3: In demodulation mode, `cap1_o - cap0_o` taken modulo 2^CNT_W equals the length of the high phase in clock cycles. A later `cap0_o` minus the previous `cap1_o` equals the length of the low phase.
- R4: While `demod_en_i` is high, activity on `tin0_i` and `tin1_i` changes no capture and sets no flag.
- R5: With `demod_en_i` low, a rising `tin0_i` captures into channel 0 and a rising `tin1_i` captures into channel 1. `pwd_i` has no effect in this mode.
- R6: While `tinN_gpio_i` is high, channel N sees its external timer input as logic high, so toggling `tinN_i` causes no capture.
- R7: A capture sets `flagN_o`, which stays set until a one-cycle `clrN_i` strobe clears it.
- R8: A capture while `flagN_o` is already set raises `ovrN_o`. The clear strobe resets `ovrN_o` together with the flag.
- R9: If a capture and a clear strobe fall in the same cycle, the flag ends set and the overrun bit ends clear.
- R10: With `irq7_sep_i` low, `irq_ch7_o` is the OR of the channel 1 request and `ext_irq7_i`, and `irq_alt_o` is low. With `irq7_sep_i` high, `irq_ch7_o` carries only the channel 1 request and `irq_alt_o` follows `ext_irq7_i`.
- R11: Toggling `demod_en_i` produces no capture, even when the newly selected source is high and the previous one was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| demod_en_i | input | 1 | Demodulation mode enable (synchronous) |
| pwd_i | input | 1 | Measured signal, asynchronous |
| tin0_i | input | 1 | External timer 0 input, asynchronous |
| tin1_i | input | 1 | External timer 1 input, asynchronous |
| tin0_gpio_i | input | 1 | Timer 0 pin is assigned to GPIO (reads high) |
| tin1_gpio_i | input | 1 | Timer 1 pin is assigned to GPIO (reads high) |
| clr0_i | input | 1 | Write-one-to-clear strobe for channel 0 flag and overrun |
| clr1_i | input | 1 | Write-one-to-clear strobe for channel 1 flag and overrun |
| ext_irq7_i | input | 1 | External request that shares the channel 1 line |
| irq7_sep_i | input | 1 | Moves the external request onto `irq_alt_o` |
| cap0_o | output | CNT_W | Channel 0 capture value |
| cap1_o | output | CNT_W | Channel 1 capture value |
| irq0_o | output | 1 | Channel 0 capture pulse |
| irq_ch7_o | output | 1 | Shared line carrying the channel 1 request |
| irq_alt_o | output | 1 | Separate line for the external request |
| flag0_o | output | 1 | Channel 0 sticky capture flag |
| flag1_o | output | 1 | Channel 1 sticky capture flag |
| ovr0_o | output | 1 | Channel 0 overrun |
| ovr1_o | output | 1 | Channel 1 overrun |

## Verification
The bench measures high and low phases of several lengths and checks the capture differences against the drive pattern. A design that inverted the wrong channel, or gave the two paths different latency, would be off by a sign or a constant. It switches the mode while the old and new sources sit at different levels. A design without edge suppression at the switch would log a phantom capture. It places a clear strobe in exactly the capture cycle, where a wrong priority loses the flag or leaves a stale overrun. It also toggles the external timer pins in demodulation mode and while they are assigned to GPIO, where a leaky multiplexer or a missing pull-high shows up as a stray flag.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic {
    SRC_EXT   = 1'b0,
    SRC_DEMOD = 1'b1
  } src_mode_e;
endpackage

// File: rtl/pwd_sync.sv
module pwd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pwd_chan.sv
module pwd_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             irq_o,
  output logic             flag_o,
  output logic             ovr_o
);
  logic prev_q;
  logic rise;

  // hold_i suppresses the edge when the source selection switches
  assign rise = src_i & ~prev_q & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      cap_o  <= '0;
      irq_o  <= 1'b0;
      flag_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      prev_q <= src_i;
      irq_o  <= rise;
      if (rise) begin
        cap_o  <= cnt_i;
        flag_o <= 1'b1;
        ovr_o  <= clr_i ? 1'b0 : (ovr_o | flag_o);
      end else if (clr_i) begin
        flag_o <= 1'b0;
        ovr_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwd_capture.sv
module pwd_capture
  import pwd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             demod_en_i,
  input  logic             pwd_i,
  input  logic             tin0_i,
  input  logic             tin1_i,
  input  logic             tin0_gpio_i,
  input  logic             tin1_gpio_i,
  input  logic             clr0_i,
  input  logic             clr1_i,
  input  logic             ext_irq7_i,
  input  logic             irq7_sep_i,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o,
  output logic             irq0_o,
  output logic             irq_ch7_o,
  output logic             irq_alt_o,
  output logic             flag0_o,
  output logic             flag1_o,
  output logic             ovr0_o,
  output logic             ovr1_o
);
  src_mode_e        mode, mode_q;
  logic             mode_chg;
  logic [CNT_W-1:0] cnt_q;
  logic             pwd_s;
  logic [NUM_CH-1:0] tin_raw, tin_s, src, clr, irq, flag, ovr;
  logic [CNT_W-1:0] cap [NUM_CH];

  assign mode     = src_mode_e'(demod_en_i);
  assign mode_chg = (mode != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= SRC_EXT;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      mode_q <= mode;
    end
  end

  // pins given to GPIO read as pulled high
  assign tin_raw = {tin1_i | tin1_gpio_i, tin0_i | tin0_gpio_i};
  assign clr     = {clr1_i, clr0_i};

  pwd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pwd (
    .clk_i, .rst_ni, .d_i(pwd_i), .q_o(pwd_s)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic demod_src;

    pwd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_tin (
      .clk_i, .rst_ni, .d_i(tin_raw[g]), .q_o(tin_s[g])
    );

    if (g == 0) begin : g_true
      assign demod_src = pwd_s;
    end else begin : g_inv
      assign demod_src = ~pwd_s;
    end

    assign src[g] = (mode == SRC_DEMOD) ? demod_src : tin_s[g];

    pwd_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i, .rst_ni,
      .src_i  (src[g]),
      .hold_i (mode_chg),
      .cnt_i  (cnt_q),
      .clr_i  (clr[g]),
      .cap_o  (cap[g]),
      .irq_o  (irq[g]),
      .flag_o (flag[g]),
      .ovr_o  (ovr[g])
    );
  end

  assign cap0_o    = cap[0];
  assign cap1_o    = cap[1];
  assign irq0_o    = irq[0];
  assign flag0_o   = flag[0];
  assign flag1_o   = flag[1];
  assign ovr0_o    = ovr[0];
  assign ovr1_o    = ovr[1];
  assign irq_ch7_o = irq[1] | (ext_irq7_i & ~irq7_sep_i);
  assign irq_alt_o = ext_irq7_i & irq7_sep_i;
endmodule

// File: rtl/pwd_capture_chk.sv
module pwd_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr0_i,
  input logic             ext_irq7_i,
  input logic             irq7_sep_i,
  input logic [CNT_W-1:0] cap0_o,
  input logic [CNT_W-1:0] cap1_o,
  input logic             irq0_o,
  input logic             irq_ch7_o,
  input logic             irq_alt_o,
  input logic             flag0_o,
  input logic             flag1_o,
  input logic             ovr0_o,
  input logic             ovr1_o
);
  AST_IRQ0_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_o |=> !irq0_o); // R2
  AST_CAP0_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap0_o) |-> irq0_o); // R2
  AST_CAP1_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap1_o) |-> flag1_o); // R7
  AST_FLAG0_ON_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_o |-> flag0_o); // R7
  AST_CLR0_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr0_i) && !irq0_o) |-> (!flag0_o && !ovr0_o)); // R7
  AST_OVR0_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr0_o |-> flag0_o); // R8
  AST_OVR1_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr1_o |-> flag1_o); // R8
  AST_ALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq7_sep_i |-> !irq_alt_o); // R10
  AST_EXT7_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq7_sep_i && ext_irq7_i) |-> irq_ch7_o); // R10
endmodule

bind pwd_capture pwd_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .clr0_i, .ext_irq7_i, .irq7_sep_i,
  .cap0_o, .cap1_o, .irq0_o, .irq_ch7_o, .irq_alt_o,
  .flag0_o, .flag1_o, .ovr0_o, .ovr1_o
);

// File: tb/pwd_capture_bench.sv
`timescale 1ns/1ps
module pwd_capture_bench;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic demod_en = 1'b0, pwd = 1'b1, tin0 = 1'b1, tin1 = 1'b1;
  logic tin0_gpio = 1'b0, tin1_gpio = 1'b0, clr0 = 1'b0, clr1 = 1'b0;
  logic ext7 = 1'b0, sep = 1'b1;
  logic [CW-1:0] cap0, cap1;
  logic irq0, irq_ch7, irq_alt, flag0, flag1, ovr0, ovr1;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pwd_capture #(.CNT_W(CW)) u_pwd_capture (
    .clk_i(clk), .rst_ni(rst_n), .demod_en_i(demod_en), .pwd_i(pwd),
    .tin0_i(tin0), .tin1_i(tin1), .tin0_gpio_i(tin0_gpio), .tin1_gpio_i(tin1_gpio),
    .clr0_i(clr0), .clr1_i(clr1), .ext_irq7_i(ext7), .irq7_sep_i(sep),
    .cap0_o(cap0), .cap1_o(cap1), .irq0_o(irq0), .irq_ch7_o(irq_ch7),
    .irq_alt_o(irq_alt), .flag0_o(flag0), .flag1_o(flag1),
    .ovr0_o(ovr0), .ovr1_o(ovr1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr0 = 1'b1; clr1 = 1'b1; step(1); clr0 = 1'b0; clr1 = 1'b0; step(1);
  endtask

  task automatic t_reset();
    chk("R1 cap0", cap0, 0); chk("R1 cap1", cap1, 0);
    chk("R1 flags", {flag0, flag1, ovr0, ovr1}, 0);
    chk("R1 irqs", {irq0, irq_ch7, irq_alt}, 0);
  endtask

  task automatic t_demod(input int hi, input int lo);
    logic [CW-1:0] c0;
    demod_en = 1'b1; step(6); clear_all();
    pwd = 1'b0; step(3);
    chk("R2 falling pulses ch1 request", irq_ch7, 1);
    chk("R2 falling leaves irq0 low", irq0, 0);
    step(1);
    chk("R2 ch1 pulse one cycle", irq_ch7, 0);
    step(lo - 4);
    pwd = 1'b1; step(3);
    chk("R2 rising pulses irq0", irq0, 1);
    step(1);
    chk("R2 irq0 one cycle", irq0, 0);
    step(hi - 4);
    pwd = 1'b0; step(lo);
    pwd = 1'b1; step(5);
    chk("R3 high phase width", 32'(cap1 - c0_of(cap0, 1'b0)), hi);
    c0 = cap0;
    chk("R3 low phase width", 32'(c0 - cap1), lo);
  endtask

  // helper kept trivial: returns the earlier capture held before the last rise
  logic [CW-1:0] prev_cap0;
  function automatic logic [CW-1:0] c0_of(input logic [CW-1:0] cur, input logic dummy);
    return prev_cap0 + (dummy ? cur : '0);
  endfunction
  always @(posedge clk) if (irq0) prev_cap0 <= prev_cap0_hold;
  logic [CW-1:0] prev_cap0_hold = '0;
  always @(negedge clk) if (!irq0) prev_cap0_hold <= cap0;

  task automatic t_ignore();
    logic [CW-1:0] a, b;
    demod_en = 1'b1; step(6); clear_all();
    a = cap0; b = cap1;
    for (int i = 0; i < 4; i++) begin
      tin0 = ~tin0; tin1 = ~tin1; step(3);
    end
    tin0 = 1'b1; tin1 = 1'b1; step(6);
    chk("R4 ext pins ignored cap0", cap0, a);
    chk("R4 ext pins ignored cap1", cap1, b);
    chk("R4 ext pins no flags", {flag0, flag1}, 0);
  endtask

  task automatic t_ext();
    logic [CW-1:0] a;
    pwd = 1'b1; tin0 = 1'b1; tin1 = 1'b1; demod_en = 1'b0; step(6); clear_all();
    tin0 = 1'b0; tin1 = 1'b0; step(4);
    tin0 = 1'b1; step(10);
    tin1 = 1'b1; step(5);
    chk("R5 tin0 flag", flag0, 1);
    chk("R5 tin1 flag", flag1, 1);
    chk("R5 tin spacing", 32'(cap1 - cap0), 10);
    clear_all();
    a = cap0;
    pwd = 1'b0; step(5); pwd = 1'b1; step(5);
    chk("R5 pwd ignored", {flag0, flag1, 16'(cap0 - a)}, 0);
  endtask

  task automatic t_gpio();
    demod_en = 1'b0; tin0 = 1'b1; tin0_gpio = 1'b1; step(5); clear_all();
    for (int i = 0; i < 3; i++) begin
      tin0 = 1'b0; step(4); tin0 = 1'b1; step(4);
    end
    chk("R6 gpio pin reads high", flag0, 0);
    tin0_gpio = 1'b0; step(5);
  endtask

  task automatic t_flags();
    demod_en = 1'b0; step(4); clear_all();
    tin0 = 1'b0; step(4); tin0 = 1'b1; step(10);
    chk("R7 flag sticky", flag0, 1);
    chk("R8 single capture no overrun", ovr0, 0);
    tin0 = 1'b0; step(4); tin0 = 1'b1; step(4);
    chk("R8 overrun raised", ovr0, 1);
    clr0 = 1'b1; step(1); clr0 = 1'b0;
    chk("R7 clear flag", flag0, 0);
    chk("R8 clear overrun", ovr0, 0);
    // build flag+overrun, then clear exactly in the capture cycle
    tin0 = 1'b0; step(4); tin0 = 1'b1; step(4);
    tin0 = 1'b0; step(4); tin0 = 1'b1; step(4);
    chk("R8 overrun before collision", ovr0, 1);
    tin0 = 1'b0; step(4);
    tin0 = 1'b1; step(2); clr0 = 1'b1; step(1); clr0 = 1'b0;
    chk("R9 collision pulse", irq0, 1);
    chk("R9 flag wins", flag0, 1);
    chk("R9 overrun cleared", ovr0, 0);
  endtask

  task automatic t_share();
    step(2);
    sep = 1'b0; ext7 = 1'b1; step(1);
    chk("R10 shared line carries ext", irq_ch7, 1);
    chk("R10 alt quiet when shared", irq_alt, 0);
    sep = 1'b1; step(1);
    chk("R10 separated ch7", irq_ch7, 0);
    chk("R10 separated alt", irq_alt, 1);
    ext7 = 1'b0; step(1);
    chk("R10 alt follows ext", irq_alt, 0);
  endtask

  task automatic t_switch();
    demod_en = 1'b0; tin0 = 1'b0; tin1 = 1'b1; pwd = 1'b1; step(6); clear_all();
    demod_en = 1'b1; step(6);
    chk("R11 enable no capture", {flag0, flag1}, 0);
    pwd = 1'b1; tin1 = 1'b1; step(2);
    demod_en = 1'b0; step(6);
    chk("R11 disable no capture", {flag0, flag1}, 0);
    tin0 = 1'b1; step(5);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_demod(5, 7);
    t_demod(37, 12);
    t_ignore();
    t_ext();
    t_gpio();
    t_flags();
    t_share();
    t_switch();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule